// File: doc/BRIEF.md
# Packed-Lane Integer Compare Unit

This unit evaluates integer compare, negate and select operations on a 64-bit word that is split into equal signed lanes. One 4-bit variant code chooses both the operation inside an opcode group and the lane size. Each lane is processed on its own as a two's complement integer. A compare operation returns a per-lane flag: the value 1 sits in the lane's lowest bit when the condition holds, and every other bit is zero.

Three opcode groups are served. Group 1 compares Y with zero. Group 2 compares Y with Z. Group 3 negates Y, or chooses per lane between Y and the current destination contents, steered by Z. Variant codes 8 to F belong to floating-point forms that this unit does not implement. An opcode group outside 1..3 is also not served. Both cases raise the unsupported flag and give a zero result. The decode and lane logic are combinational. A single register stage holds the result, so an operation presented before a rising clock edge is visible after it.

Top module: `lane_compare_unit`

## Requirements
- R1: Group 1 with variant 0..3 sets each lane to 1 when that lane of Y is zero. Variant bits [1:0] pick the lane size: 0 gives one 64-bit lane, 1 gives two 32-bit lanes, 2 gives four 16-bit lanes and 3 gives eight 8-bit lanes. Lane 0 is in the lowest bits.
- R2: Group 1 with variant 4..7 sets each lane to 1 when that lane of Y is negative as a signed value. The lane size is chosen by bits [1:0] as in R1.
- R3: Group 2 with variant 0..3 sets each lane to 1 when the Y and Z lanes are equal.
- R4: Group 2 with variant 4..7 sets each lane to 1 when the Y lane is less than the Z lane, both taken as signed values.
- R5: Every compare result holds 0 or 1 in bit 0 of each lane and zero in all other bits of that lane.
- R6: Group 3 with variant 0..3 writes the two's complement negation of each Y lane. The most negative lane value maps to itself.
- R7: Group 3 with variant 4..7 writes the Y lane where the matching Z lane is non-zero. Otherwise it writes the matching lane of the destination input.
- R8: Variant 8..F, or an opcode group other than 1, 2 or 3, sets the unsupported output to 1 and the result to zero. Any served operation sets the unsupported output to 0.
- R9: While reset is active, the result and the unsupported output are zero. Otherwise both reflect the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rstN | input | 1 | Asynchronous active-low reset |
| opGroup | input | 4 | Opcode group; 1, 2 and 3 are served |
| variant | input | 4 | Operation and lane-size selector |
| opY | input | 64 | First operand |
| opZ | input | 64 | Second operand, or the select control for R7 |
| destIn | input | 64 | Current destination value for the select operation |
| result | output | 64 | Registered packed-lane result |
| unsupported | output | 1 | Registered flag for an operation this unit does not serve |

## Verification
The compare operations are tried with several operand sets. Words with some lanes zero and others not show whether lane boundaries are placed correctly at each size. Lanes at the signed extremes (0x80.. against 0x7f..) separate signed ordering from unsigned ordering. Equal operands separate less-than from less-or-equal. Negation is given the most negative lane value to show the wrap, and the select operation gets a Z with mixed zero and non-zero lanes. Unsupported variants and unserved groups are paired with non-zero operands, so a result that leaks through shows up, and a long random sweep across every group and variant is compared against an independent lane model.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  localparam int DATA_W = 64;
  localparam int NUM_SIZES = 4;
  localparam int SIZE_SEL_W = $clog2(NUM_SIZES);

  typedef enum logic [2:0] {
    OP_NONE,
    OP_EQZ,
    OP_LTZ,
    OP_EQ,
    OP_LT,
    OP_NEG,
    OP_SEL
  } opKind_e;

  typedef struct packed {
    opKind_e kind;
    logic [SIZE_SEL_W-1:0] sizeSel;
    logic unsup;
  } ctrlStrobe_s;
endpackage

// File: rtl/lcu_ctrl.sv
module lcu_ctrl
  import lcu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  opGroup,
  input  logic [3:0]  variant,
  output ctrlStrobe_s strobe,
  output logic        unsupported
);
  always_comb begin
    strobe.kind    = OP_NONE;
    strobe.sizeSel = variant[SIZE_SEL_W-1:0];
    strobe.unsup   = 1'b0;
    if (variant[3]) begin
      strobe.unsup = 1'b1;
    end else begin
      unique case (opGroup)
        4'd1:    strobe.kind = variant[2] ? OP_LTZ : OP_EQZ;
        4'd2:    strobe.kind = variant[2] ? OP_LT  : OP_EQ;
        4'd3:    strobe.kind = variant[2] ? OP_SEL : OP_NEG;
        default: strobe.unsup = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unsupported <= 1'b0;
    else       unsupported <= strobe.unsup;
  end
endmodule

// File: rtl/lcu_datapath.sv
module lcu_datapath
  import lcu_pkg::*;
#(
  parameter int WORD_W = DATA_W,
  parameter int SIZES  = NUM_SIZES
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_s       strobe,
  input  logic [WORD_W-1:0] opY,
  input  logic [WORD_W-1:0] opZ,
  input  logic [WORD_W-1:0] destIn,
  output logic [WORD_W-1:0] result
);
  logic [SIZES-1:0][WORD_W-1:0] sizeRes;
  logic [WORD_W-1:0] nextRes;

  for (genvar s = 0; s < SIZES; s++) begin : g_size
    localparam int LANE_W = WORD_W >> s;
    localparam int LANES  = 1 << s;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] yLane, zLane, dLane, laneOut;
      logic flag;
      assign yLane = opY[l*LANE_W +: LANE_W];
      assign zLane = opZ[l*LANE_W +: LANE_W];
      assign dLane = destIn[l*LANE_W +: LANE_W];

      always_comb begin
        flag = 1'b0;
        laneOut = '0;
        unique case (strobe.kind)
          OP_EQZ: flag = (yLane == '0);
          OP_LTZ: flag = yLane[LANE_W-1];
          OP_EQ:  flag = (yLane == zLane);
          OP_LT:  flag = ($signed(yLane) < $signed(zLane));
          OP_NEG: laneOut = '0 - yLane;
          OP_SEL: laneOut = (zLane != '0) ? yLane : dLane;
          default: laneOut = '0;
        endcase
        if (strobe.kind inside {OP_EQZ, OP_LTZ, OP_EQ, OP_LT})
          laneOut = LANE_W'(flag);
      end

      assign sizeRes[s][l*LANE_W +: LANE_W] = laneOut;
    end
  end

  assign nextRes = strobe.unsup ? '0 : sizeRes[strobe.sizeSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= nextRes;
  end
endmodule

// File: rtl/lane_compare_unit.sv
module lane_compare_unit
  import lcu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opGroup,
  input  logic [3:0]        variant,
  input  logic [DATA_W-1:0] opY,
  input  logic [DATA_W-1:0] opZ,
  input  logic [DATA_W-1:0] destIn,
  output logic [DATA_W-1:0] result,
  output logic              unsupported
);
  ctrlStrobe_s strobe;

  lcu_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opGroup     (opGroup),
    .variant     (variant),
    .strobe      (strobe),
    .unsupported (unsupported)
  );

  lcu_datapath #(.WORD_W(DATA_W), .SIZES(NUM_SIZES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opY    (opY),
    .opZ    (opZ),
    .destIn (destIn),
    .result (result)
  );
endmodule

// File: rtl/lcu_checker.sv
module lcu_checker (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  opGroup,
  input logic [3:0]  variant,
  input logic [63:0] opY,
  input logic [63:0] opZ,
  input logic [63:0] destIn,
  input logic [63:0] result,
  input logic        unsupported
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  function automatic logic [63:0] lsbMask(input logic [1:0] sel);
    logic [63:0] m;
    int w;
    m = '0;
    w = 64 >> sel;
    for (int i = 0; i < 64; i += w) m[i] = 1'b1;
    return m;
  endfunction

  assert_unsup_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> (result == 64'd0));

  assert_float_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(variant[3])) |-> unsupported);

  assert_flag_lsb_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && ($past(opGroup) == 4'd1 || $past(opGroup) == 4'd2) && !$past(variant[3]))
      |-> ((result & ~lsbMask($past(variant[1:0]))) == 64'd0));

  assert_eq64_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(opGroup) == 4'd2 && $past(variant) == 4'd0)
      |-> (result == {63'd0, $past(opY) == $past(opZ)}));

  assert_neg64_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(opGroup) == 4'd3 && $past(variant) == 4'd0)
      |-> (result == 64'd0 - $past(opY)));

  assert_sel64_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(opGroup) == 4'd3 && $past(variant) == 4'd4)
      |-> (result == (($past(opZ) != 64'd0) ? $past(opY) : $past(destIn))));
endmodule

bind lane_compare_unit lcu_checker u_lcu_checker (
  .clk         (clk),
  .rstN        (rstN),
  .opGroup     (opGroup),
  .variant     (variant),
  .opY         (opY),
  .opZ         (opZ),
  .destIn      (destIn),
  .result      (result),
  .unsupported (unsupported)
);

// File: tb/lane_compare_unit_test.sv
module lane_compare_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opGroup = 4'd2;
  logic [3:0]  variant = 4'd0;
  logic [63:0] opY = 64'h5;
  logic [63:0] opZ = 64'h5;
  logic [63:0] destIn = 64'h0;
  logic [63:0] result;
  logic        unsupported;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        uns;
    string       tag;
  } item_s;
  item_s sb[$];

  always #4 clk = ~clk;

  lane_compare_unit uut (
    .clk(clk), .rstN(rstN), .opGroup(opGroup), .variant(variant),
    .opY(opY), .opZ(opZ), .destIn(destIn),
    .result(result), .unsupported(unsupported)
  );

  function automatic void model(input logic [3:0] g, input logic [3:0] v,
                                input logic [63:0] y, input logic [63:0] z,
                                input logic [63:0] d,
                                output logic [63:0] r, output logic u);
    int lw;
    int n;
    logic [63:0] mask;
    lw = 64 >> v[1:0];
    n = 64 / lw;
    mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    r = '0;
    u = 1'b0;
    if (v[3] || g == 4'd0 || g > 4'd3) begin
      u = 1'b1;
      return;
    end
    for (int i = 0; i < n; i++) begin
      logic [63:0] yl, zl, dl, lane;
      longint ys, zs;
      yl = (y >> (i * lw)) & mask;
      zl = (z >> (i * lw)) & mask;
      dl = (d >> (i * lw)) & mask;
      ys = longint'(yl << (64 - lw)) >>> (64 - lw);
      zs = longint'(zl << (64 - lw)) >>> (64 - lw);
      case (g)
        4'd1:    lane = v[2] ? {63'd0, ys < 0} : {63'd0, yl == 64'd0};
        4'd2:    lane = v[2] ? {63'd0, ys < zs} : {63'd0, yl == zl};
        default: lane = v[2] ? ((zl != 64'd0) ? yl : dl) : ((64'd0 - yl) & mask);
      endcase
      r |= (lane & mask) << (i * lw);
    end
  endfunction

  function automatic string tagOf(input logic [3:0] g, input logic [3:0] v);
    if (v[3] || g == 4'd0 || g > 4'd3) return "R8";
    case (g)
      4'd1:    return v[2] ? "R2/R5" : "R1/R5";
      4'd2:    return v[2] ? "R4/R5" : "R3/R5";
      default: return v[2] ? "R7" : "R6";
    endcase
  endfunction

  // driver: present one operation and queue its expected outcome
  task automatic apply(input logic [3:0] g, input logic [3:0] v,
                       input logic [63:0] y, input logic [63:0] z,
                       input logic [63:0] d);
    item_s it;
    @(negedge clk);
    opGroup = g; variant = v; opY = y; opZ = z; destIn = d;
    model(g, v, y, z, d, it.res, it.uns);
    it.tag = tagOf(g, v);
    sb.push_back(it);
  endtask

  // monitor: result is registered, so it is due just after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_s it;
        it = sb.pop_front();
        checks++;
        if (result !== it.res || unsupported !== it.uns) begin
          errors++;
          $display("FAIL %s (R9 timing): result=%h unsupported=%b expected result=%h unsupported=%b",
                   it.tag, result, unsupported, it.res, it.uns);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs at zero although a matching compare is applied
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (result !== 64'd0 || unsupported !== 1'b0) begin
      errors++;
      $display("FAIL R9: result=%h unsupported=%b expected result=0 unsupported=0",
               result, unsupported);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R1 zero tests at each lane size
    apply(4'd1, 4'h0, 64'd0, 64'd0, 64'd0);
    apply(4'd1, 4'h0, 64'h8000_0000_0000_0000, 64'd0, 64'd0);
    apply(4'd1, 4'h1, 64'h0000_0000_1234_5678, 64'd0, 64'd0);
    apply(4'd1, 4'h2, 64'h0000_ff00_0000_0001, 64'd0, 64'd0);
    apply(4'd1, 4'h3, 64'h00ff_00ff_00ff_00ff, 64'd0, 64'd0);
    // R2 sign tests
    apply(4'd1, 4'h4, 64'h8000_0000_0000_0000, 64'd0, 64'd0);
    apply(4'd1, 4'h4, 64'h7fff_ffff_ffff_ffff, 64'd0, 64'd0);
    apply(4'd1, 4'h5, 64'h8000_0000_7fff_ffff, 64'd0, 64'd0);
    apply(4'd1, 4'h6, 64'hffff_0001_8000_0000, 64'd0, 64'd0);
    apply(4'd1, 4'h7, 64'h807f_ff00_0180_7f81, 64'd0, 64'd0);
    // R3 equality
    apply(4'd2, 4'h0, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 64'd0);
    apply(4'd2, 4'h0, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def1, 64'd0);
    apply(4'd2, 4'h1, 64'haaaa_aaaa_5555_5555, 64'haaaa_aaaa_5555_5554, 64'd0);
    apply(4'd2, 4'h3, 64'h0102_0304_0506_0708, 64'h0102_0004_0506_0008, 64'd0);
    // R4 signed less-than, extremes and equal operands
    apply(4'd2, 4'h4, 64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff, 64'd0);
    apply(4'd2, 4'h4, 64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 64'd0);
    apply(4'd2, 4'h4, 64'h42, 64'h42, 64'd0);
    apply(4'd2, 4'h7, 64'h8080_8080_8080_8080, 64'h7f7f_7f7f_7f7f_7f7f, 64'd0);
    apply(4'd2, 4'h6, 64'hffff_0000_0005_8000, 64'h0000_ffff_0005_7fff, 64'd0);
    // R6 negation incl. most negative lanes
    apply(4'd3, 4'h0, 64'h8000_0000_0000_0000, 64'd0, 64'd0);
    apply(4'd3, 4'h0, 64'h1, 64'd0, 64'd0);
    apply(4'd3, 4'h1, 64'h0000_0001_ffff_ffff, 64'd0, 64'd0);
    apply(4'd3, 4'h2, 64'h8000_7fff_0000_0001, 64'd0, 64'd0);
    apply(4'd3, 4'h3, 64'h8001_ff00_7f80_0203, 64'd0, 64'd0);
    // R7 conditional select
    apply(4'd3, 4'h4, 64'h1111_1111_1111_1111, 64'd0, 64'hdddd_dddd_dddd_dddd);
    apply(4'd3, 4'h4, 64'h1111_1111_1111_1111, 64'h100, 64'hdddd_dddd_dddd_dddd);
    apply(4'd3, 4'h5, 64'h1111_1111_2222_2222, 64'h0000_0000_0000_0001, 64'hdddd_dddd_eeee_eeee);
    apply(4'd3, 4'h7, 64'h0102_0304_0506_0708, 64'h00ff_0001_0000_8000, 64'ha1a2_a3a4_a5a6_a7a8);
    // R8 unsupported variants and groups
    apply(4'd2, 4'h8, 64'h5, 64'h5, 64'h5);
    apply(4'd1, 4'hf, 64'd0, 64'd0, 64'hffff);
    apply(4'd3, 4'hc, 64'h1234, 64'h1, 64'h9);
    apply(4'd0, 4'h0, 64'd0, 64'd0, 64'h77);
    apply(4'd4, 4'h4, 64'h8000_0000_0000_0000, 64'h1, 64'h1);
    // random sweep across all groups and variants
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ry, rz, rd;
      ry = {$urandom, $urandom};
      rz = {$urandom, $urandom};
      rd = {$urandom, $urandom};
      if (k % 3 == 0) rz = ry ^ {32'd0, $urandom & 32'h00ff_0000};
      if (k % 5 == 0) ry = ry & 64'hff00_00ff_0000_ffff;
      apply(4'($urandom_range(0, 4)), 4'($urandom_range(0, 15)), ry, rz, rd);
    end
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule